// File: doc/BRIEF.md
# Serial Slave Hold Controller

This block sits in front of the shifters of a serial memory slave and lets the bus master pause a transfer without losing its place. Chip select, serial clock, a pause input and serial data in come from the pins. An oversampling core clock brings them into one domain through two-flop synchronizers. The block produces a qualified strobe for each rising serial clock edge, with the sampled data bit. It also gives a qualified strobe for each falling edge, which advances the output shifter, and the output-enable for the data-out pin. A frame bit counter shows how far the shifter has got.

Holds follow the falling edge of the serial clock. A pause requested while the clock is low takes effect at once. A pause requested while the clock is high waits for the next falling edge. A pause ends only on the first falling edge after the pause input returns high. While paused, clock edges and data are masked and the output pin is released. The bit position is frozen, so the transfer resumes where it stopped. If the master deselects the device in the middle of a pause, the block issues a one-cycle reset pulse for the protocol state.

Top module: `sio_hold_ctrl`

## Requirements
- R1: After reset, sdo_oe_o, sdi_valid_o, shift_en_o and proto_rst_o are 0 and bit_cnt_o is 0.
- R2: With chip select low and no pause, each rising serial clock edge gives exactly one sdi_valid_o pulse, with sdi_bit_o equal to the serial data level at that edge. bit_cnt_o then steps by one and wraps from FRAME_BITS-1 to 0.
- R3: With chip select low and no pause, each falling serial clock edge gives exactly one shift_en_o pulse.
- R4: If hold_ni goes low while the serial clock is low, the pause starts without waiting for a clock edge. If hold_ni goes low while the clock is high, the pause starts at the next falling edge, and that edge still gives its shift_en_o pulse.
- R5: During a pause, no sdi_valid_o or shift_en_o pulses occur whatever the serial clock and data do, and bit_cnt_o holds its value from pause entry.
- R6: Raising hold_ni does not end the pause by itself. The pause ends on the first falling serial clock edge after that, and that edge gives no shift_en_o pulse.
- R7: sdo_oe_o equals drive_req_i while the device is selected and not paused. It is 0 during a pause, and it follows drive_req_i again once the pause ends.
- R8: While chip select is high, hold_ni has no effect: sdo_oe_o is 0, no strobes occur and bit_cnt_o is 0.
- R9: If chip select goes high during a pause, proto_rst_o pulses high for exactly one cycle. Deselecting with no pause in effect gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| hold_ni | input | 1 | Pause request pin, active low |
| sdi_i | input | 1 | Serial data in pin |
| drive_req_i | input | 1 | Core request to drive the data-out pin |
| sdi_valid_o | output | 1 | Qualified rising-edge strobe |
| sdi_bit_o | output | 1 | Data bit sampled with sdi_valid_o |
| shift_en_o | output | 1 | Qualified falling-edge strobe for the output shifter |
| sdo_oe_o | output | 1 | Data-out pin output enable |
| proto_rst_o | output | 1 | One-cycle protocol state reset |
| bit_cnt_o | output | CNT_W | Bit position inside the current frame |

## Verification
Frames of eight bits are sent with a pause inserted at the first, a middle and the last bit position. Some pauses are requested in the low clock phase and some in the high phase. The low-phase cases show that entry happens at once. The high-phase cases show that entry waits for a falling edge and that this edge still counts. A varying number of masked clock toggles with scrambled data checks that no strobe or count leaks through, and the received byte must come back intact. Separate tests take hold_ni high with no falling edge, hold the pause while deselected, and drop chip select during a pause. These tell apart release on the level of hold_ni from release on the clock edge, and a deselect with a pause from one without.

// File: rtl/sio_hold_pkg.sv
package sio_hold_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FRAME_BITS  = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sio_hold_fsm.sv
module sio_hold_fsm
  import sio_hold_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_s_i,
  input  logic       hold_s_i,
  input  logic       sclk_s_i,
  output sclk_edge_t edge_o,
  output logic       hold_active_o,
  output logic       proto_rst_o
);
  logic sclk_d, cs_d, hold_q, hold_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s_i;
      cs_d   <= cs_s_i;
    end
  end

  assign edge_o.rise = sclk_s_i & ~sclk_d;
  assign edge_o.fall = ~sclk_s_i & sclk_d;

  // entry while clock low is level based; release waits for a falling edge
  always_comb begin
    hold_d = hold_q;
    if (cs_s_i)                           hold_d = 1'b0;
    else if (!hold_q)                     hold_d = ~hold_s_i & ~sclk_s_i;
    else if (hold_s_i && edge_o.fall)     hold_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end

  assign hold_active_o = hold_q;
  assign proto_rst_o   = cs_s_i & ~cs_d & hold_q;

  // R6
  hold_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !cs_s_i && !edge_o.fall |=> hold_q);
  // R8
  desel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !hold_q);
  // R9
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_rst_o |=> !proto_rst_o);
endmodule

// File: rtl/sio_bit_counter.sv
module sio_bit_counter #(
  parameter int unsigned FRAME_BITS = 8,
  localparam int unsigned CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i |=> cnt_o == (($past(cnt_o) == LAST) ? '0 : $past(cnt_o) + 1'b1));
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(cnt_o));
endmodule

// File: rtl/sio_hold_ctrl.sv
module sio_hold_ctrl
  import sio_hold_pkg::*;
#(
  parameter int unsigned FRAME_BITS = sio_hold_pkg::FRAME_BITS,
  localparam int unsigned CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             hold_ni,
  input  logic             sdi_i,
  input  logic             drive_req_i,
  output logic             sdi_valid_o,
  output logic             sdi_bit_o,
  output logic             shift_en_o,
  output logic             sdo_oe_o,
  output logic             proto_rst_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  logic       cs_s, hold_s, sclk_s, sdi_s;
  logic       hold_active, run;
  sclk_edge_t sclk_edge;

  // sdi rides the same pipeline so it lines up with the edge detect
  sio_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, hold_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, hold_s, sclk_s, sdi_s})
  );

  sio_hold_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_s_i       (cs_s),
    .hold_s_i     (hold_s),
    .sclk_s_i     (sclk_s),
    .edge_o       (sclk_edge),
    .hold_active_o(hold_active),
    .proto_rst_o  (proto_rst_o)
  );

  assign run         = ~cs_s & ~hold_active;
  assign sdi_valid_o = run & sclk_edge.rise;
  assign shift_en_o  = run & sclk_edge.fall;
  assign sdi_bit_o   = sdi_s;
  assign sdo_oe_o    = run & drive_req_i;

  sio_bit_counter #(
    .FRAME_BITS(FRAME_BITS)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cs_s),
    .inc_i (sdi_valid_o),
    .cnt_o (bit_cnt_o)
  );

  // R5
  hold_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_active |-> !sdi_valid_o && !shift_en_o);
  // R7
  hold_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_active |-> !sdo_oe_o);
  // R8
  desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !sdo_oe_o && !sdi_valid_o && !shift_en_o);
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sdi_valid_o, shift_en_o}));
endmodule

// File: tb/sio_hold_ctrl_test.sv
module sio_hold_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, sdi = 1'b0, drive = 1'b0;
  logic sdi_valid_o, sdi_bit_o, shift_en_o, sdo_oe_o, proto_rst_o;
  logic [2:0] bit_cnt_o;

  int checks = 0, errors = 0;
  int vcnt = 0, fcnt = 0, pcnt = 0;
  logic [7:0] rx = '0;

  always #5 clk = ~clk;

  sio_hold_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .hold_ni(hold_n),
    .sdi_i(sdi), .drive_req_i(drive), .sdi_valid_o(sdi_valid_o), .sdi_bit_o(sdi_bit_o),
    .shift_en_o(shift_en_o), .sdo_oe_o(sdo_oe_o), .proto_rst_o(proto_rst_o),
    .bit_cnt_o(bit_cnt_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (sdi_valid_o) begin vcnt++; rx = {rx[6:0], sdi_bit_o}; end
    if (shift_en_o) fcnt++;
    if (proto_rst_o) pcnt++;
  end

  // data8, pos3, high-phase1, toggles4
  localparam logic [15:0] VEC [6] = '{
    {8'hA5, 3'd0, 1'b0, 4'd2},
    {8'h3C, 3'd3, 1'b1, 4'd3},
    {8'hFF, 3'd7, 1'b0, 4'd1},
    {8'h00, 3'd7, 1'b1, 4'd2},
    {8'h5A, 3'd4, 1'b0, 4'd0},
    {8'hC3, 3'd1, 1'b1, 4'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hold_body(input int exp_cnt, input int ntog);
    int v0, f0;
    chk(sdo_oe_o == 1'b0, "R7 oe off in pause", int'(sdo_oe_o), 0);
    chk(int'(bit_cnt_o) == exp_cnt, "R5 count frozen at entry", int'(bit_cnt_o), exp_cnt);
    v0 = vcnt; f0 = fcnt;
    for (int t = 0; t < ntog; t++) begin
      sdi = ~sdi; sclk = 1'b1; wait_clk(4);
      sdi = ~sdi; sclk = 1'b0; wait_clk(4);
    end
    chk(vcnt == v0 && fcnt == f0, "R5 edges masked", vcnt + fcnt, v0 + f0);
    chk(int'(bit_cnt_o) == exp_cnt, "R5 count unchanged", int'(bit_cnt_o), exp_cnt);
    hold_n = 1'b1; wait_clk(4);
    chk(sdo_oe_o == 1'b0, "R6 pause kept until falling edge", int'(sdo_oe_o), 0);
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0; wait_clk(4);
    chk(fcnt == f0 && vcnt == v0, "R6 exit edge not counted", fcnt + vcnt, f0 + v0);
    chk(sdo_oe_o == 1'b1, "R7 oe restored", int'(sdo_oe_o), 1);
  endtask

  task automatic frame(input logic [7:0] d, input int pos, input bit hi, input int ntog);
    int v0, f0;
    v0 = vcnt; f0 = fcnt;
    for (int i = 0; i < 8; i++) begin
      if (i == pos && !hi) begin
        hold_n = 1'b0; wait_clk(4);
        hold_body(pos, ntog);
      end
      sdi = d[7-i]; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
      if (i == pos && hi) begin
        hold_n = 1'b0; wait_clk(4);
        chk(sdo_oe_o == 1'b1, "R4 entry waits for falling edge", int'(sdo_oe_o), 1);
      end
      sclk = 1'b0; wait_clk(4);
      if (i == pos && hi) hold_body((pos + 1) % 8, ntog);
    end
    chk(rx == d, "R2 byte intact", int'(rx), int'(d));
    chk(vcnt - v0 == 8, "R2 one strobe per rising edge", vcnt - v0, 8);
    chk(fcnt - f0 == 8, "R3 one strobe per falling edge", fcnt - f0, 8);
    chk(bit_cnt_o == 3'd0, "R2 count wraps", int'(bit_cnt_o), 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    #1;
    chk(sdo_oe_o == 0 && sdi_valid_o == 0 && shift_en_o == 0 && proto_rst_o == 0,
        "R1 outputs idle in reset", int'(sdo_oe_o), 0);
    chk(bit_cnt_o == 3'd0, "R1 count zero", int'(bit_cnt_o), 0);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R8: deselected, pause and clocks ignored
    drive = 1'b1; hold_n = 1'b0;
    for (int t = 0; t < 3; t++) begin
      sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    chk(vcnt == 0 && fcnt == 0, "R8 no strobes deselected", vcnt + fcnt, 0);
    chk(sdo_oe_o == 1'b0, "R8 oe off deselected", int'(sdo_oe_o), 0);
    chk(bit_cnt_o == 3'd0, "R8 count zero deselected", int'(bit_cnt_o), 0);
    hold_n = 1'b1; wait_clk(4);
    cs_n = 1'b0; wait_clk(4);
    chk(sdo_oe_o == 1'b1, "R7 oe follows request", int'(sdo_oe_o), 1);
    drive = 1'b0; wait_clk(1);
    chk(sdo_oe_o == 1'b0, "R7 oe follows request low", int'(sdo_oe_o), 0);
    drive = 1'b1; wait_clk(1);

    for (int k = 0; k < 6; k++)
      frame(VEC[k][15:8], int'(VEC[k][7:5]), VEC[k][4], int'(VEC[k][3:0]));

    // R9: plain deselect gives no pulse
    p0 = pcnt;
    cs_n = 1'b1; wait_clk(6);
    chk(pcnt == p0, "R9 no pulse without pause", pcnt - p0, 0);

    // R9: deselect in the middle of a pause
    cs_n = 1'b0; wait_clk(4);
    sdi = 1'b1; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    hold_n = 1'b0; wait_clk(4);
    chk(bit_cnt_o == 3'd1, "R5 count at pause", int'(bit_cnt_o), 1);
    p0 = pcnt;
    cs_n = 1'b1; wait_clk(6);
    chk(pcnt - p0 == 1, "R9 single reset pulse", pcnt - p0, 1);
    chk(bit_cnt_o == 3'd0, "R8 count cleared", int'(bit_cnt_o), 0);
    hold_n = 1'b1; wait_clk(4);
    cs_n = 1'b0; wait_clk(4);
    frame(8'h96, 2, 1'b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule